// File: doc/BRIEF.md
# Double-Buffered Bulk IN Endpoint Transmit Buffer

This block holds outgoing packets for one bulk or interrupt IN endpoint of a USB device function. It has two packet banks. Firmware loads bytes into whichever bank is currently being filled and then marks that bank ready. The fill pointer then moves to the other bank, so the next packet can be loaded while the first one waits for the host.

On the bus side the block receives abstracted IN token pulses and host handshake results, which are either an acknowledge or a timeout. It answers each token with a one-cycle response code. The code is a NAK when the endpoint is disabled or the bank due to be sent is not ready. Otherwise it is a data response tagged with the current data toggle, and the bank's bytes follow as a valid/last stream. An acknowledge frees the bank, advances the send pointer and the toggle, and sets a transmit-complete flag that can raise an interrupt. A timeout leaves everything in place, so the same packet is offered again.

Top module: `pp_in_endpoint`

## Requirements
- R1: While `ep_enable` is low, every IN token gets a NAK response and no bytes are streamed. One cycle with `ep_enable` low clears both ready flags, both byte counts, both bank pointers (back to bank 0), the data toggle (back to DATA0), `tx_cmpl` and `overflow`. Writes made while disabled are dropped.
- R2: An `in_token` pulse taken while no transaction is outstanding produces a response two clock edges later. The response is a `rsp_valid` pulse lasting exactly one cycle. `rsp_is_data` is 1 for a data response and 0 for a NAK.
- R3: A token is answered with a NAK, and no bytes, when the ready flag of the current send bank is clear.
- R4: After reset, both `fill_bank` and the send bank point at bank 0. Each `fw_set_ready` sets the ready flag of the fill bank (`bank_ready[b]` for bank b) and moves `fill_bank` to the other bank. A `fw_set_ready` is ignored if the fill bank is already ready.
- R5: After a data response, the send bank's bytes appear on `tx_data` in the order they were written. The first byte comes in the cycle after `rsp_valid`, then one byte per cycle with `tx_valid` high, and `tx_last` is high on the final byte. A bank with zero bytes gives a data response and no stream.
- R6: A `host_ack` taken after the stream has ended does four things: it clears the send bank's ready flag and byte count, moves the send pointer to the other bank, and sets `tx_cmpl`. `irq` equals `tx_cmpl` AND `irq_en`.
- R7: `rsp_pid` is 0 for DATA0 and 1 for DATA1. The first data response after enable uses DATA0, and the value flips on each acknowledged packet only.
- R8: A `host_timeout` after a data response changes no state. The next token resends the same bank with the same PID.
- R9: Each bank holds up to 64 bytes. A write to a full bank is dropped and sets `overflow`, which stays set until the endpoint is disabled.
- R10: While the fill bank's ready flag is set (both banks full), firmware writes are dropped.
- R11: `fw_clr_cmpl` clears `tx_cmpl`. If an acknowledge arrives in the same cycle, `tx_cmpl` ends up set.
- R12: An `in_token` that arrives while a transaction is outstanding (from a data response until its handshake) is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ep_enable | input | 1 | Endpoint enabled and configured |
| irq_en | input | 1 | Interrupt enable for transmit complete |
| fw_wr_en | input | 1 | Firmware byte write strobe |
| fw_wr_data | input | 8 | Firmware byte |
| fw_set_ready | input | 1 | Mark the fill bank ready |
| fw_clr_cmpl | input | 1 | Clear the transmit-complete flag |
| fill_bank | output | 1 | Bank currently being filled |
| bank_ready | output | 2 | Ready flag per bank |
| tx_cmpl | output | 1 | Transmit-complete flag |
| overflow | output | 1 | Sticky bank overflow flag |
| irq | output | 1 | Interrupt request |
| in_token | input | 1 | IN token pulse for this endpoint |
| host_ack | input | 1 | Host acknowledged the packet |
| host_timeout | input | 1 | Host did not acknowledge |
| rsp_valid | output | 1 | Response code strobe |
| rsp_is_data | output | 1 | 1 = data response, 0 = NAK |
| rsp_pid | output | 1 | 0 = DATA0, 1 = DATA1 |
| tx_valid | output | 1 | Packet byte valid |
| tx_data | output | 8 | Packet byte |
| tx_last | output | 1 | Final byte of packet |

## Verification
The hardest state to reach is the one where both banks are ready and firmware keeps pushing, combined with a resend after a timeout. In that state, extra ready strobes and writes must be dropped, while the retried bank must come out with the same PID and the same bytes. The directed sequence fills both banks, retries one packet after a timeout, pokes a token into the outstanding window, and lines up an acknowledge with a complete-clear in the same cycle. A seeded random run then mixes bursts of up to 70 bytes, ready strobes, acknowledged and timed-out transactions, and re-enables, all checked against a bench model of the two banks.

// File: rtl/pp_in_pkg.sv
package pp_in_pkg;

    // Bus-side transaction engine states
    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_DECIDE = 2'd1,
        ENG_STREAM = 2'd2,
        ENG_AWAIT  = 2'd3
    } eng_state_e;

    localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/pp_bank_store.sv
module pp_bank_store #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    import pp_in_pkg::*;

    logic [NUM_BANKS-1:0][DW-1:0] bank_word;
    logic [DW-1:0] rd_d, rd_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [DW-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b))) begin
                mem[wr_addr] <= wr_data;
            end
        end

        assign bank_word[b] = mem[rd_addr];
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d = bank_word[rd_bank];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/pp_bank_ctrl.sv
module pp_bank_ctrl #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ep_enable,
    input  logic          fw_wr_en,
    input  logic          fw_set_ready,
    input  logic          fw_clr_cmpl,
    input  logic          ack_evt,
    output logic          wr_ok,
    output logic          wr_bank,
    output logic [AW-1:0] wr_addr,
    output logic          fill_bank,
    output logic          send_bank,
    output logic [1:0]    bank_ready,
    output logic [CW-1:0] send_count,
    output logic          send_ready,
    output logic          pid_odd,
    output logic          tx_cmpl,
    output logic          overflow
);
    import pp_in_pkg::*;

    typedef struct packed {
        logic [NUM_BANKS-1:0]         rdy;
        logic [NUM_BANKS-1:0][CW-1:0] cnt;
        logic                         fill;
        logic                         send;
        logic                         tog;
        logic                         cmpl;
        logic                         ovf;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d   = c_q;
        wr_ok = 1'b0;
        if (!ep_enable) begin
            c_d = '0;
        end else begin
            if (fw_wr_en && !c_q.rdy[c_q.fill]) begin
                if (c_q.cnt[c_q.fill] == CW'(DEPTH)) begin
                    c_d.ovf = 1'b1;
                end else begin
                    wr_ok = 1'b1;
                    c_d.cnt[c_q.fill] = c_q.cnt[c_q.fill] + 1'b1;
                end
            end
            if (ack_evt) begin
                c_d.rdy[c_q.send] = 1'b0;
                c_d.cnt[c_q.send] = '0;
                c_d.send          = ~c_q.send;
                c_d.tog           = ~c_q.tog;
                c_d.cmpl          = 1'b1;
            end else if (fw_clr_cmpl) begin
                c_d.cmpl = 1'b0;
            end
            if (fw_set_ready && !c_q.rdy[c_q.fill]) begin
                c_d.rdy[c_q.fill] = 1'b1;
                c_d.fill          = ~c_q.fill;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign wr_bank    = c_q.fill;
    assign wr_addr    = c_q.cnt[c_q.fill][AW-1:0];
    assign fill_bank  = c_q.fill;
    assign send_bank  = c_q.send;
    assign bank_ready = c_q.rdy;
    assign send_count = c_q.cnt[c_q.send];
    assign send_ready = c_q.rdy[c_q.send];
    assign pid_odd    = c_q.tog;
    assign tx_cmpl    = c_q.cmpl;
    assign overflow   = c_q.ovf;

    // R6
    ack_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_evt && ep_enable) |=> (send_bank != $past(send_bank)) && tx_cmpl);

    // R7
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_evt && ep_enable) |=> (pid_odd == $past(pid_odd)));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && ep_enable) |=> overflow);

    // R1
    dis_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_enable |=> (bank_ready == 2'b00) && !pid_odd && !fill_bank);

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_count <= CW'(DEPTH));

endmodule

// File: rtl/pp_tx_engine.sv
module pp_tx_engine #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ep_enable,
    input  logic          in_token,
    input  logic          host_ack,
    input  logic          host_timeout,
    input  logic          send_ready,
    input  logic [CW-1:0] send_count,
    input  logic          pid_odd,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          ack_evt,
    output logic          rsp_valid,
    output logic          rsp_is_data,
    output logic          rsp_pid,
    output logic          tx_valid,
    output logic          tx_last
);
    import pp_in_pkg::*;

    typedef struct packed {
        eng_state_e    st;
        logic [CW-1:0] idx;
        logic [CW-1:0] len;
        logic          rsp_v;
        logic          rsp_d;
        logic          rsp_p;
        logic          txv;
        logic          txl;
    } eng_t;

    eng_t e_d, e_q;
    logic last_byte;

    assign last_byte = (e_q.idx == (e_q.len - 1'b1));

    always_comb begin
        e_d       = e_q;
        e_d.rsp_v = 1'b0;
        e_d.txv   = 1'b0;
        e_d.txl   = 1'b0;
        ack_evt   = 1'b0;
        case (e_q.st)
            ENG_IDLE: begin
                if (in_token) begin
                    e_d.st = ENG_DECIDE;
                end
            end
            ENG_DECIDE: begin
                e_d.rsp_v = 1'b1;
                if (ep_enable && send_ready) begin
                    e_d.rsp_d = 1'b1;
                    e_d.rsp_p = pid_odd;
                    e_d.idx   = '0;
                    e_d.len   = send_count;
                    e_d.st    = (send_count == '0) ? ENG_AWAIT : ENG_STREAM;
                end else begin
                    e_d.rsp_d = 1'b0;
                    e_d.rsp_p = 1'b0;
                    e_d.st    = ENG_IDLE;
                end
            end
            ENG_STREAM: begin
                e_d.txv = 1'b1;
                e_d.txl = last_byte;
                e_d.idx = e_q.idx + 1'b1;
                if (last_byte) begin
                    e_d.st = ENG_AWAIT;
                end
            end
            ENG_AWAIT: begin
                if (host_ack) begin
                    ack_evt = 1'b1;
                    e_d.st  = ENG_IDLE;
                end else if (host_timeout) begin
                    e_d.st = ENG_IDLE;
                end
            end
            default: e_d.st = ENG_IDLE;
        endcase
        if (!ep_enable && (e_q.st == ENG_STREAM || e_q.st == ENG_AWAIT)) begin
            e_d.st  = ENG_IDLE;
            e_d.txv = 1'b0;
            e_d.txl = 1'b0;
            ack_evt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign rd_en       = (e_q.st == ENG_STREAM);
    assign rd_addr     = e_q.idx[AW-1:0];
    assign rsp_valid   = e_q.rsp_v;
    assign rsp_is_data = e_q.rsp_d;
    assign rsp_pid     = e_q.rsp_p;
    assign tx_valid    = e_q.txv;
    assign tx_last     = e_q.txl;

    // R2
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2
    rsp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_token && e_q.st == ENG_IDLE) |=> ##1 rsp_valid);

    // R3
    nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ENG_DECIDE && !send_ready) |=> (rsp_valid && !rsp_is_data));

    // R5
    last_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    // R12
    busy_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ENG_STREAM || e_q.st == ENG_AWAIT) |=> (e_q.st != ENG_DECIDE));

endmodule

// File: rtl/pp_in_endpoint.sv
module pp_in_endpoint #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ep_enable,
    input  logic          irq_en,
    input  logic          fw_wr_en,
    input  logic [DW-1:0] fw_wr_data,
    input  logic          fw_set_ready,
    input  logic          fw_clr_cmpl,
    output logic          fill_bank,
    output logic [1:0]    bank_ready,
    output logic          tx_cmpl,
    output logic          overflow,
    output logic          irq,
    input  logic          in_token,
    input  logic          host_ack,
    input  logic          host_timeout,
    output logic          rsp_valid,
    output logic          rsp_is_data,
    output logic          rsp_pid,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          tx_last
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic          wr_ok, wr_bank, send_bank, send_ready, pid_odd, ack_evt, rd_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [CW-1:0] send_count;

    pp_bank_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ep_enable  (ep_enable),
        .fw_wr_en   (fw_wr_en),
        .fw_set_ready(fw_set_ready),
        .fw_clr_cmpl(fw_clr_cmpl),
        .ack_evt    (ack_evt),
        .wr_ok      (wr_ok),
        .wr_bank    (wr_bank),
        .wr_addr    (wr_addr),
        .fill_bank  (fill_bank),
        .send_bank  (send_bank),
        .bank_ready (bank_ready),
        .send_count (send_count),
        .send_ready (send_ready),
        .pid_odd    (pid_odd),
        .tx_cmpl    (tx_cmpl),
        .overflow   (overflow)
    );

    pp_bank_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .wr_bank (wr_bank),
        .wr_addr (wr_addr),
        .wr_data (fw_wr_data),
        .rd_en   (rd_en),
        .rd_bank (send_bank),
        .rd_addr (rd_addr),
        .rd_data (tx_data)
    );

    pp_tx_engine #(.DEPTH(DEPTH)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .ep_enable   (ep_enable),
        .in_token    (in_token),
        .host_ack    (host_ack),
        .host_timeout(host_timeout),
        .send_ready  (send_ready),
        .send_count  (send_count),
        .pid_odd     (pid_odd),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .ack_evt     (ack_evt),
        .rsp_valid   (rsp_valid),
        .rsp_is_data (rsp_is_data),
        .rsp_pid     (rsp_pid),
        .tx_valid    (tx_valid),
        .tx_last     (tx_last)
    );

    assign irq = tx_cmpl & irq_en;

    // R6
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (tx_cmpl && irq_en));

endmodule

// File: tb/pp_in_endpoint_test.sv
module pp_in_endpoint_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ep_enable = 1'b0, irq_en = 1'b0;
    logic fw_wr_en = 1'b0, fw_set_ready = 1'b0, fw_clr_cmpl = 1'b0;
    logic [7:0] fw_wr_data = '0;
    logic in_token = 1'b0, host_ack = 1'b0, host_timeout = 1'b0;
    logic fill_bank, tx_cmpl, overflow, irq;
    logic [1:0] bank_ready;
    logic rsp_valid, rsp_is_data, rsp_pid, tx_valid, tx_last;
    logic [7:0] tx_data;

    pp_in_endpoint uut (
        .clk(clk), .rst_n(rst_n), .ep_enable(ep_enable), .irq_en(irq_en),
        .fw_wr_en(fw_wr_en), .fw_wr_data(fw_wr_data), .fw_set_ready(fw_set_ready),
        .fw_clr_cmpl(fw_clr_cmpl), .fill_bank(fill_bank), .bank_ready(bank_ready),
        .tx_cmpl(tx_cmpl), .overflow(overflow), .irq(irq), .in_token(in_token),
        .host_ack(host_ack), .host_timeout(host_timeout), .rsp_valid(rsp_valid),
        .rsp_is_data(rsp_is_data), .rsp_pid(rsp_pid), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;

    // bench model
    logic [7:0] mbuf [2][DEPTH];
    int  mcnt [2];
    bit [1:0] mrdy;
    int  mfill, msend;
    bit  mtog, mcmpl, movf, men;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model_clear();
        mcnt[0] = 0; mcnt[1] = 0; mrdy = 2'b00; mfill = 0; msend = 0;
        mtog = 0; mcmpl = 0; movf = 0;
    endfunction

    function automatic void model_ack();
        mrdy[msend] = 1'b0;
        mcnt[msend] = 0;
        msend ^= 1;
        mtog = ~mtog;
        mcmpl = 1'b1;
    endfunction

    task automatic check_flags(input string ctx);
        chk(bank_ready == mrdy, {"R4 bank_ready ", ctx}, bank_ready, mrdy);
        chk(fill_bank == 1'(mfill), {"R4 fill_bank ", ctx}, fill_bank, mfill);
        chk(tx_cmpl == mcmpl, {"R6 tx_cmpl ", ctx}, tx_cmpl, mcmpl);
        chk(overflow == movf, {"R9 overflow ", ctx}, overflow, movf);
        chk(irq == (mcmpl & irq_en), {"R6 irq ", ctx}, irq, mcmpl & irq_en);
    endtask

    task automatic wr(input logic [7:0] v);
        fw_wr_en = 1'b1; fw_wr_data = v;
        @(negedge clk);
        fw_wr_en = 1'b0;
        if (men && !mrdy[mfill]) begin
            if (mcnt[mfill] == DEPTH) movf = 1'b1;
            else begin
                mbuf[mfill][mcnt[mfill]] = v;
                mcnt[mfill]++;
            end
        end
    endtask

    task automatic setrdy();
        fw_set_ready = 1'b1;
        @(negedge clk);
        fw_set_ready = 1'b0;
        if (men && !mrdy[mfill]) begin
            mrdy[mfill] = 1'b1;
            mfill ^= 1;
        end
    endtask

    task automatic clrc();
        fw_clr_cmpl = 1'b1;
        @(negedge clk);
        fw_clr_cmpl = 1'b0;
        if (men) mcmpl = 1'b0;
    endtask

    task automatic set_en(input bit v);
        ep_enable = v;
        men = v;
        @(negedge clk);
        if (!v) model_clear();
    endtask

    // hs: 0 = ack, 1 = timeout, 2 = ack with simultaneous complete-clear
    task automatic in_txn(input int hs, input bit poke);
        bit exp_data;
        int n;
        exp_data = men && mrdy[msend];
        n = mcnt[msend];
        in_token = 1'b1;
        @(negedge clk);
        in_token = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b1, "R2 response strobe", rsp_valid, 1);
        chk(rsp_is_data == exp_data, exp_data ? "R5 data response" : "R3 NAK response",
            rsp_is_data, exp_data);
        if (!men) chk(rsp_is_data == 1'b0, "R1 NAK while disabled", rsp_is_data, 0);
        if (!exp_data) begin
            @(negedge clk);
            chk(tx_valid == 1'b0 && rsp_valid == 1'b0, "R3 no bytes after NAK", tx_valid, 0);
            return;
        end
        chk(rsp_pid == mtog, "R7 PID", rsp_pid, mtog);
        if (n == 0) begin
            @(negedge clk);
            chk(tx_valid == 1'b0, "R5 zero-length stream", tx_valid, 0);
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tx_valid == 1'b1, "R5 tx_valid", tx_valid, 1);
            chk(tx_data == mbuf[msend][i], "R5 tx_data", tx_data, mbuf[msend][i]);
            chk(tx_last == (i == n - 1), "R5 tx_last", tx_last, (i == n - 1));
        end
        if (poke) begin
            in_token = 1'b1;
            @(negedge clk);
            in_token = 1'b0;
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R12 token ignored", rsp_valid, 0);
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R12 token ignored late", rsp_valid, 0);
        end
        if (hs == 1) begin
            host_timeout = 1'b1;
            @(negedge clk);
            host_timeout = 1'b0;
        end else begin
            host_ack = 1'b1;
            if (hs == 2) fw_clr_cmpl = 1'b1;
            @(negedge clk);
            host_ack = 1'b0;
            fw_clr_cmpl = 1'b0;
            model_ack();
            if (hs == 2) chk(tx_cmpl == 1'b1, "R11 ack wins over clear", tx_cmpl, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R2 watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model_clear();
        men = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check_flags("after reset");
        chk(rsp_valid == 0 && tx_valid == 0, "R2 idle outputs after reset", rsp_valid, 0);

        // R1: disabled endpoint answers NAK, drops writes
        wr(8'h11);
        in_txn(0, 0);
        set_en(1'b1);
        check_flags("R1 writes dropped while disabled");

        // R3: nothing ready
        in_txn(0, 0);

        // R4/R10: fill both banks
        irq_en = 1'b1;
        wr(8'hA1); wr(8'hA2); wr(8'hA3);
        setrdy();
        check_flags("R4 first ready");
        for (int i = 0; i < 5; i++) wr(8'(8'hB0 + i));
        setrdy();
        check_flags("R4 both ready");
        setrdy();
        wr(8'hEE);
        check_flags("R10 full banks");

        // R8 timeout then resend, R6 ack, R12 poke
        in_txn(1, 0);
        check_flags("R8 after timeout");
        in_txn(0, 1);
        check_flags("R6 after ack");
        clrc();
        check_flags("R11 clear");
        in_txn(0, 0);
        check_flags("R6 second ack");

        // R5 zero-length, R11 ack+clear together
        setrdy();
        in_txn(2, 0);
        check_flags("R11 ack with clear");

        // R9 overflow
        for (int i = 0; i < 66; i++) wr(8'(i * 3));
        check_flags("R9 overflow");
        setrdy();
        in_txn(0, 0);
        check_flags("R9 after full packet");

        // R1 disable clears everything, R7 toggle restarts at DATA0
        set_en(1'b0);
        check_flags("R1 after disable");
        set_en(1'b1);
        wr(8'h5A); setrdy();
        chk(1'b1, "R7 restart setup", 0, 0);
        in_txn(0, 0);
        check_flags("R7 restart");

        // constrained random
        for (int it = 0; it < 600; it++) begin
            int r;
            r = int'($urandom_range(0, 19));
            if (r < 6) begin
                int len;
                len = ($urandom_range(0, 15) == 0) ? 70 : int'($urandom_range(0, 8));
                for (int k = 0; k < len; k++) wr(8'($urandom));
            end else if (r < 9) setrdy();
            else if (r < 14) in_txn(0, $urandom_range(0, 7) == 0);
            else if (r < 16) in_txn(1, 0);
            else if (r < 18) clrc();
            else if (r < 19) irq_en = ~irq_en;
            else begin
                set_en(1'b0);
                set_en(1'b1);
            end
            @(negedge clk);
            check_flags("random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule